// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Offset Flags

This block is a first-in first-out buffer of 64 words by 36 bits that joins two unrelated clock domains. A producer writes on `clk_wr` and a consumer reads on `clk_rd`. Each side sees two active-low status flags resolved in its own clock. The write side sees a full flag and an almost-full flag. The read side sees an empty flag and an almost-empty flag.

Each pointer crosses to the other domain in Gray code through a two-flop synchronizer. Flags driven by a side's own accesses change right after that side's clock edge. Flags driven by the far side's accesses change two of the observing side's edges later.

One offset value X sets both almost thresholds. X is taken from a 2-bit preset selector while reset is held low, and it stays fixed until the next reset. A port access takes effect only when both its select and its enable are high and its blocking flag is high.

Top module: `dcf_fifo`

## Requirements
- R1: Words come out of `rd_data` in the order they were written, with all 36 bits intact, and up to 64 words can be held at once.
- R2: A write is accepted on a rising `clk_wr` edge when `wr_sel`, `wr_en` and `full_n` are all high, and each accepted write advances the write position by exactly one.
- R3: `full_n` goes low right after the `clk_wr` edge that stores the 64th word, and while it is low a write attempt stores nothing.
- R4: `empty_n` goes low right after the `clk_rd` edge that removes the last word, and while it is low a read attempt changes neither `rd_data` nor the read position.
- R5: After a write into an empty FIFO, `empty_n` is still low after the first rising `clk_rd` edge, is high after the second, and the word can then be read on the next edge.
- R6: After a read from a full FIFO, `full_n` is still low after the first rising `clk_wr` edge and is high after the second.
- R7: Once settled, `aempty_n` is low when X or fewer words are stored and high when X+1 or more are stored.
- R8: Once settled, `afull_n` is low when 64-X or more words are stored and high when 63-X or fewer are stored.
- R9: X is captured from `offset_sel` while `rst_n` is low, with 2'b00 giving 4, 2'b01 giving 8, 2'b10 giving 16 and 2'b11 giving 32. Changing `offset_sel` after reset has no effect.
- R10: After reset, `empty_n` and `aempty_n` are low, `full_n` and `afull_n` are high, and `rd_data` is zero.
- R11: `rd_data` keeps its last value in every `clk_rd` cycle in which no read is accepted.
- R12: With `wr_sel` low a write enable stores nothing, and with `rd_sel` low a read enable returns nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock |
| clk_rd | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| offset_sel | input | 2 | Preset choice for X, captured during reset |
| wr_sel | input | 1 | Write port select |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when 64 words are stored |
| afull_n | output | 1 | Low when 64-X or more words are stored |
| rd_sel | input | 1 | Read port select |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Output register holding the last word read |
| empty_n | output | 1 | Low when no word is stored |
| aempty_n | output | 1 | Low when X or fewer words are stored |

## Verification
The hardest situation to reach from the ports is the exact flag release after a far-side access: the edge count must be observed against a clock that is not the one that caused the change. The stimulus runs the read clock at a third of the write rate with a fixed phase, so no edge of one clock falls within two time units of an edge of the other. Writes and reads are then issued one at a time, and the far-side flag is sampled just after each of the next two edges of its own clock. Threshold edges for three of the presets are reached by writing single words and letting both domains settle before each flag comparison.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Gray code to binary; callers pass a zero-extended pointer and slice the result.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Offset preset: a power-of-two fraction of the depth.
    function automatic int unsigned ofs_words(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return depth / 16;
            2'd1:    return depth / 8;
            2'd2:    return depth / 4;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        stg_d[1] = stg_q[0];
        if (!rst_n) begin
            stg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW    = 36,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_wr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Storage carries no reset; entries are only read after being written.
    always_ff @(posedge clk_wr) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel,
    input  logic          en,
    input  logic [PW-1:0] rgray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] ofs,
    output logic          full_n,
    output logic          afull_n
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rptr_b;
    logic [PW-1:0] fill;
    logic          full, afull, accept;

    always_comb begin
        st_d   = st_q;
        rptr_b = PW'(gray_to_bin(32'(rgray_sync)));
        fill   = st_q.ptr - rptr_b;
        full   = (fill == PW'(DEPTH));
        afull  = (fill >= (PW'(DEPTH) - st_q.ofs));
        accept = sel && en && !full;
        if (accept) begin
            st_d.ptr  = st_q.ptr + PW'(1);
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (!rst_n) begin
            st_d.ptr  = '0;
            st_d.gray = '0;
            st_d.ofs  = PW'(ofs_words(ofs_sel, DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign we      = accept;
    assign waddr   = st_q.ptr[AW-1:0];
    assign wgray   = st_q.gray;
    assign wptr    = st_q.ptr;
    assign ofs     = st_q.ofs;
    assign full_n  = !full;
    assign afull_n = !afull;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DW    = 36,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel,
    input  logic          en,
    input  logic [PW-1:0] wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rptr,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          aempty_n
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [PW-1:0] ofs;
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wptr_b;
    logic [PW-1:0] fill;
    logic          empty, aempty, accept;

    always_comb begin
        st_d   = st_q;
        wptr_b = PW'(gray_to_bin(32'(wgray_sync)));
        fill   = wptr_b - st_q.ptr;
        empty  = (fill == '0);
        aempty = (fill <= st_q.ofs);
        accept = sel && en && !empty;
        if (accept) begin
            st_d.data = mem_rdata;
            st_d.ptr  = st_q.ptr + PW'(1);
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (!rst_n) begin
            st_d.ptr  = '0;
            st_d.gray = '0;
            st_d.data = '0;
            st_d.ofs  = PW'(ofs_words(ofs_sel, DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raddr    = st_q.ptr[AW-1:0];
    assign rgray    = st_q.gray;
    assign rptr     = st_q.ptr;
    assign rd_data  = st_q.data;
    assign empty_n  = !empty;
    assign aempty_n = !aempty;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 64
) (
    input  logic              clk_wr,
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic [1:0]        offset_sel,
    input  logic              wr_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_sel,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;
    logic [PW-1:0] wptr_bin, rptr_bin, ofs_wr;
    logic [DATA_W-1:0] mem_rdata;

    dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk(clk_wr), .rst_n(rst_n), .ofs_sel(offset_sel),
        .sel(wr_sel), .en(wr_en), .rgray_sync(rgray_sync),
        .we(we), .waddr(waddr), .wgray(wgray), .wptr(wptr_bin),
        .ofs(ofs_wr), .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_ctl #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .clk(clk_rd), .rst_n(rst_n), .ofs_sel(offset_sel),
        .sel(rd_sel), .en(rd_en), .wgray_sync(wgray_sync),
        .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
        .rptr(rptr_bin), .rd_data(rd_data), .empty_n(empty_n),
        .aempty_n(aempty_n)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(clk_rd), .rst_n(rst_n), .din(wgray), .dout(wgray_sync)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(clk_wr), .rst_n(rst_n), .din(rgray), .dout(rgray_sync)
    );

    dcf_mem #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk_wr(clk_wr), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int DW = 36,
    parameter int PW = 7
) (
    input logic          clk_wr,
    input logic          clk_rd,
    input logic          rst_n,
    input logic          wr_sel,
    input logic          wr_en,
    input logic          rd_sel,
    input logic          rd_en,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wptr_bin,
    input logic [PW-1:0] rptr_bin,
    input logic [PW-1:0] ofs_wr
);
    p_wr_step_r2: assert property (@(posedge clk_wr) disable iff (!rst_n)
        (wr_sel && wr_en && full_n) |=> (wptr_bin == $past(wptr_bin) + PW'(1)));

    p_no_overflow_r3: assert property (@(posedge clk_wr) disable iff (!rst_n)
        !full_n |=> $stable(wptr_bin));

    p_no_underflow_r4: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !empty_n |=> $stable(rptr_bin));

    p_empty_aempty_r7: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    p_full_afull_r8: assert property (@(posedge clk_wr) disable iff (!rst_n)
        !full_n |-> !afull_n);

    p_ofs_fixed_r9: assert property (@(posedge clk_wr) disable iff (!rst_n)
        rst_n |=> $stable(ofs_wr));

    p_ofs_preset_r9: assert property (@(posedge clk_wr) disable iff (!rst_n)
        $countones(ofs_wr) == 1);

    p_rdata_hold_r11: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !(rd_sel && rd_en && empty_n) |=> $stable(rd_data));

    p_wr_gate_r12: assert property (@(posedge clk_wr) disable iff (!rst_n)
        !(wr_sel && wr_en) |=> $stable(wptr_bin));

    p_rd_gate_r12: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !(rd_sel && rd_en) |=> $stable(rptr_bin));
endmodule

bind dcf_fifo dcf_chk #(.DW(DATA_W), .PW(PW)) u_chk (
    .clk_wr(clk_wr), .clk_rd(clk_rd), .rst_n(rst_n),
    .wr_sel(wr_sel), .wr_en(wr_en), .rd_sel(rd_sel), .rd_en(rd_en),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n),
    .aempty_n(aempty_n), .rd_data(rd_data), .wptr_bin(wptr_bin),
    .rptr_bin(rptr_bin), .ofs_wr(ofs_wr)
);

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RD_HALF    = 15;
    localparam int DW         = 36;
    localparam int DEPTH      = 64;

    logic          clk_wr = 1'b0;
    logic          clk_rd = 1'b0;
    logic          rst_n  = 1'b0;
    logic [1:0]    offset_sel = 2'd0;
    logic          wr_sel = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0, rd_en = 1'b0;
    logic          full_n, afull_n, empty_n, aempty_n;
    logic [DW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    dcf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk_wr(clk_wr), .clk_rd(clk_rd), .rst_n(rst_n),
        .offset_sel(offset_sel), .wr_sel(wr_sel), .wr_en(wr_en),
        .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
        .rd_sel(rd_sel), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // Write edges at 5+10k, read edges at 8+30k: never closer than 3 time units.
    initial forever #(CLK_PERIOD/2) clk_wr = ~clk_wr;
    initial begin
        #8 clk_rd = 1'b1;
        forever #RD_HALF clk_rd = ~clk_rd;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk_rd);
        repeat (4) @(posedge clk_wr);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0; offset_sel = sel;
        wr_sel = 1'b0; wr_en = 1'b0; rd_sel = 1'b0; rd_en = 1'b0;
        repeat (4) @(posedge clk_rd);
        #1 rst_n = 1'b1;
        settle();
    endtask

    // Returns one time unit after the accepting write edge.
    task automatic wr_word(input logic [DW-1:0] d);
        @(posedge clk_wr); #1;
        wr_sel = 1'b1; wr_en = 1'b1; wr_data = d;
        @(posedge clk_wr); #1;
        wr_sel = 1'b0; wr_en = 1'b0;
    endtask

    // Returns one time unit after the accepting read edge.
    task automatic rd_word(output logic [DW-1:0] d);
        @(posedge clk_rd); #1;
        rd_sel = 1'b1; rd_en = 1'b1;
        @(posedge clk_rd); #1;
        rd_sel = 1'b0; rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        do_reset(2'd0);
        check("R10 empty_n", 64'(empty_n), 64'd0);
        check("R10 aempty_n", 64'(aempty_n), 64'd0);
        check("R10 full_n", 64'(full_n), 64'd1);
        check("R10 afull_n", 64'(afull_n), 64'd1);
        check("R10 rd_data", 64'(rd_data), 64'd0);
    endtask

    task automatic t_empty_latency();
        logic [DW-1:0] d;
        wr_word(36'h1_2345_6789);
        @(posedge clk_rd); #1;
        check("R5 empty_n after first read edge", 64'(empty_n), 64'd0);
        @(posedge clk_rd); #1;
        check("R5 empty_n after second read edge", 64'(empty_n), 64'd1);
        rd_word(d);
        check("R1 R5 word read", 64'(d), 64'h1_2345_6789);
        check("R4 empty_n right after last read", 64'(empty_n), 64'd0);
        repeat (3) @(posedge clk_rd); #1;
        check("R11 rd_data held", 64'(rd_data), 64'h1_2345_6789);
    endtask

    task automatic t_read_empty();
        logic [DW-1:0] d;
        rd_word(d);
        check("R4 read while empty keeps rd_data", 64'(d), 64'h1_2345_6789);
        wr_word(36'hA_0000_00F0);
        settle();
        rd_word(d);
        check("R4 read position not advanced", 64'(d), 64'hA_0000_00F0);
    endtask

    task automatic t_select();
        logic [DW-1:0] d;
        @(posedge clk_wr); #1;
        wr_sel = 1'b0; wr_en = 1'b1; wr_data = 36'h3_3333_3333;
        repeat (5) @(posedge clk_wr); #1;
        wr_en = 1'b0;
        settle();
        check("R12 write without select", 64'(empty_n), 64'd0);
        wr_word(36'h4_4444_4444);
        settle();
        @(posedge clk_rd); #1;
        rd_sel = 1'b0; rd_en = 1'b1;
        repeat (5) @(posedge clk_rd); #1;
        rd_en = 1'b0;
        check("R12 read without select rd_data", 64'(rd_data), 64'hA_0000_00F0);
        check("R12 read without select empty_n", 64'(empty_n), 64'd1);
        rd_word(d);
        check("R12 word after gated read", 64'(d), 64'h4_4444_4444);
    endtask

    task automatic t_full();
        logic [DW-1:0] d;
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) begin
                settle();
                check("R3 full_n high at 63 words", 64'(full_n), 64'd1);
            end
            wr_word(36'(64'h5_0000_1000 + 64'(i)));
        end
        check("R3 full_n low right after 64th write", 64'(full_n), 64'd0);
        wr_word(36'hF_FFFF_FFFF);
        settle();
        check("R3 full_n still low", 64'(full_n), 64'd0);
        check("R8 afull_n at 64 words", 64'(afull_n), 64'd0);
        rd_word(d);
        check("R1 first word of full run", 64'(d), 64'h5_0000_1000);
        @(posedge clk_wr); #1;
        check("R6 full_n after first write edge", 64'(full_n), 64'd0);
        @(posedge clk_wr); #1;
        check("R6 full_n after second write edge", 64'(full_n), 64'd1);
        for (int i = 1; i < DEPTH; i++) begin
            rd_word(d);
            if (d !== 36'(64'h5_0000_1000 + 64'(i))) bad++;
        end
        check("R1 order of 64 words", 64'(bad), 64'd0);
        settle();
        check("R3 write while full dropped", 64'(empty_n), 64'd0);
    endtask

    task automatic t_thresh(input logic [1:0] sel, input int x);
        do_reset(sel);
        offset_sel = ~sel;  // R9: must not matter after reset
        for (int n = 1; n <= DEPTH; n++) begin
            wr_word(36'(n));
            if (n == x || n == x + 1 || n == DEPTH - x - 1 || n == DEPTH - x) begin
                settle();
                check($sformatf("R7 R9 aempty_n X=%0d n=%0d", x, n),
                      64'(aempty_n), 64'(n > x));
                check($sformatf("R8 R9 afull_n X=%0d n=%0d", x, n),
                      64'(afull_n), 64'(n < DEPTH - x));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_empty_latency();
        t_read_empty();
        t_select();
        t_full();
        t_thresh(2'd0, 4);
        t_thresh(2'd3, 32);
        t_thresh(2'd1, 8);
        done = 1'b1;
        finish_run();
    end
endmodule